// File: doc/BRIEF.md
# Conditional Skip Chain Controller

This block handles the control side of conditional instructions in a 16-bit processor core. Each instruction is presented once, marked by a one-cycle step strobe. The strobe comes with the decoded basic opcode, the two operand mode fields and the outcome of the operand comparison. Conditional opcodes test two operands. When a test fails, the controller arms a skip flag, and the next instruction is then consumed without being executed. The block reports how far the program counter moves and how many cycles the step costs. The comparator and the operand fetch sit outside the block. The controller tells the comparator which kind of test the current opcode asks for.

The operand mode fields set the length of the instruction. The base word counts as one, and each operand field that reads an extra word from the instruction stream adds one more. A skipped instruction is stepped over by its full length, so its trailing words are never decoded as instructions. If the instruction being skipped is itself a conditional, the skip flag stays armed. A whole chain of nested conditionals is therefore passed over together, at one cycle per skipped conditional. While the flag is armed, interrupts are held off, so a pending request is accepted only once the chain has ended.

All results are registered and appear, with a valid flag, in the cycle after the step. The skip flag is a register that is visible at the ports.

Top module: `cond_skip_ctrl`

## Requirements
- R1: After reset, `skip_o`, `res_valid_o`, `exec_o` and `irq_take_o` are 0.
- R2: Only opcodes 0x10 to 0x17 are conditionals. Any other opcode, for example 0x0f or 0x18, charges 0 cycles from this block and never arms the skip flag, whatever `test_pass_i` is.
- R3: A conditional that is executed and whose test passes charges 2 cycles (`cyc_add_o` = 2) and leaves `skip_o` at 0.
- R4: A conditional that is executed and whose test fails charges 3 cycles and sets `skip_o` to 1.
- R5: When `skip_o` is 1, a non-conditional instruction gives `exec_o` = 0 and `cyc_add_o` = 0, moves the program counter by its full length and clears `skip_o`.
- R6: When `skip_o` is 1, a conditional instruction gives `exec_o` = 0 and `cyc_add_o` = 1, moves the program counter by its full length and keeps `skip_o` at 1, whatever `test_pass_i` is.
- R7: `pc_adv_o` is 1 plus one for each operand field whose code uses an extra word. The codes that use an extra word are 0x10 to 0x17, 0x1a, 0x1e and 0x1f. Codes 0x20 and above in the 6-bit A field (inline literals) add nothing.
- R8: `irq_take_o` is 1 after a step only if `irq_pend_i` was high at that step and `skip_o` is 0 after the step.
- R9: A step result is reported with `res_valid_o` = 1 in the cycle after the step strobe. Cycles without a strobe report `res_valid_o` = 0 and leave `skip_o` unchanged.
- R10: `cmp_kind_o` is combinational and equals opcode minus 0x10 for a conditional. The codes run 0 bit-set, 1 bit-clear, 2 equal, 3 not-equal, 4 unsigned greater, 5 signed greater, 6 unsigned less, 7 signed less. For any other opcode it is 0.
- R11: An instruction stepped while `skip_o` is 0 gives `exec_o` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step_i | input | 1 | One-cycle strobe: an instruction is presented |
| opcode_i | input | 5 | Decoded basic opcode |
| fld_a_i | input | 6 | Operand A mode code |
| fld_b_i | input | 5 | Operand B mode code |
| test_pass_i | input | 1 | Comparison outcome for a conditional |
| irq_pend_i | input | 1 | Interrupt request waiting |
| cmp_kind_o | output | 3 | Test kind requested from the comparator |
| res_valid_o | output | 1 | Step result valid |
| exec_o | output | 1 | Stepped instruction executes |
| pc_adv_o | output | 2 | Program counter advance in words |
| cyc_add_o | output | 4 | Cycles charged by this block |
| irq_take_o | output | 1 | Interrupt may be accepted after this step |
| skip_o | output | 1 | Skip flag |

## Verification
The assertions take two things for granted. First, `step_i` is a clean one-cycle-per-instruction strobe with no X values. Second, the opcode and mode fields are stable while the strobe is high, so the registered result can be related to the previous cycle's inputs with `$past`. The stimulus keeps to this by changing every input only on the falling clock edge, by raising the strobe for exactly one instruction per cycle, and by putting strobe-free gaps in the middle of skip chains.

// File: rtl/csc_pkg.sv
`timescale 1ns/1ps
package csc_pkg;

    typedef enum logic [2:0] {
        CK_BIT_SET   = 3'd0,
        CK_BIT_CLR   = 3'd1,
        CK_EQUAL     = 3'd2,
        CK_NOT_EQUAL = 3'd3,
        CK_UGT       = 3'd4,
        CK_SGT       = 3'd5,
        CK_ULT       = 3'd6,
        CK_SLT       = 3'd7
    } cmp_kind_e;

    localparam int unsigned MODE_W = 6;

    // Operand codes that pull one extra word from the instruction stream
    function automatic logic mode_uses_word(input logic [MODE_W-1:0] code);
        logic hit;
        hit = 1'b0;
        if (code >= 6'h10 && code <= 6'h17) hit = 1'b1;
        if (code == 6'h1a)                  hit = 1'b1;
        if (code == 6'h1e || code == 6'h1f) hit = 1'b1;
        return hit;
    endfunction

endpackage

// File: rtl/csc_field_ext.sv
`timescale 1ns/1ps
module csc_field_ext #(
    parameter int unsigned FIELD_W = 6
) (
    input  logic [FIELD_W-1:0] code_i,
    output logic               extra_o
);
    import csc_pkg::*;

    logic [MODE_W-1:0] code_wide;

    generate
        if (FIELD_W >= MODE_W) begin : g_trunc
            assign code_wide = code_i[MODE_W-1:0];
        end else begin : g_pad
            assign code_wide = {{(MODE_W-FIELD_W){1'b0}}, code_i};
        end
    endgenerate

    always_comb begin
        extra_o = mode_uses_word(code_wide);
    end
endmodule

// File: rtl/csc_len_dec.sv
`timescale 1ns/1ps
module csc_len_dec #(
    parameter int unsigned FA_W  = 6,
    parameter int unsigned FB_W  = 5,
    parameter int unsigned LEN_W = 2
) (
    input  logic [FA_W-1:0]  fld_a_i,
    input  logic [FB_W-1:0]  fld_b_i,
    output logic [LEN_W-1:0] len_o
);
    logic ext_a;
    logic ext_b;

    csc_field_ext #(.FIELD_W(FA_W)) u_ext_a (
        .code_i  (fld_a_i),
        .extra_o (ext_a)
    );

    csc_field_ext #(.FIELD_W(FB_W)) u_ext_b (
        .code_i  (fld_b_i),
        .extra_o (ext_b)
    );

    always_comb begin
        len_o = LEN_W'(1) + LEN_W'(ext_a) + LEN_W'(ext_b);
    end
endmodule

// File: rtl/csc_cond_dec.sv
`timescale 1ns/1ps
module csc_cond_dec #(
    parameter int unsigned OP_W       = 5,
    parameter int unsigned COND_BASE  = 16,
    parameter int unsigned COND_COUNT = 8,
    parameter int unsigned KIND_W     = 3
) (
    input  logic [OP_W-1:0]   opcode_i,
    output logic              is_cond_o,
    output logic [KIND_W-1:0] kind_o
);
    localparam int unsigned COND_LAST = COND_BASE + COND_COUNT - 1;

    logic [OP_W-1:0] offset;

    always_comb begin
        is_cond_o = (32'(opcode_i) >= COND_BASE) && (32'(opcode_i) <= COND_LAST);
        offset    = opcode_i - OP_W'(COND_BASE);
        kind_o    = is_cond_o ? offset[KIND_W-1:0] : '0;
    end
endmodule

// File: rtl/csc_cost.sv
`timescale 1ns/1ps
module csc_cost #(
    parameter int unsigned CYC_W     = 4,
    parameter int unsigned COST_BASE = 2,
    parameter int unsigned COST_FAIL = 1,
    parameter int unsigned COST_SKIP = 1
) (
    input  logic             skipping_i,
    input  logic             is_cond_i,
    input  logic             pass_i,
    output logic [CYC_W-1:0] cyc_o,
    output logic             arm_o
);
    always_comb begin
        cyc_o = '0;
        arm_o = 1'b0;
        if (is_cond_i) begin
            if (skipping_i) begin
                cyc_o = CYC_W'(COST_SKIP);
                arm_o = 1'b1;
            end else if (pass_i) begin
                cyc_o = CYC_W'(COST_BASE);
            end else begin
                cyc_o = CYC_W'(COST_BASE + COST_FAIL);
                arm_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/cond_skip_ctrl.sv
`timescale 1ns/1ps
module cond_skip_ctrl #(
    parameter int unsigned OP_W       = 5,
    parameter int unsigned FA_W       = 6,
    parameter int unsigned FB_W       = 5,
    parameter int unsigned LEN_W      = 2,
    parameter int unsigned CYC_W      = 4,
    parameter int unsigned COND_BASE  = 16,
    parameter int unsigned COND_COUNT = 8,
    parameter int unsigned COST_BASE  = 2,
    parameter int unsigned COST_FAIL  = 1,
    parameter int unsigned COST_SKIP  = 1,
    localparam int unsigned KIND_W    = $clog2(COND_COUNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic [OP_W-1:0]   opcode_i,
    input  logic [FA_W-1:0]   fld_a_i,
    input  logic [FB_W-1:0]   fld_b_i,
    input  logic              test_pass_i,
    input  logic              irq_pend_i,
    output logic [KIND_W-1:0] cmp_kind_o,
    output logic              res_valid_o,
    output logic              exec_o,
    output logic [LEN_W-1:0]  pc_adv_o,
    output logic [CYC_W-1:0]  cyc_add_o,
    output logic              irq_take_o,
    output logic              skip_o
);

    typedef struct packed {
        logic             skip;
        logic             valid;
        logic             exec;
        logic             irq;
        logic [LEN_W-1:0] adv;
        logic [CYC_W-1:0] cyc;
    } ctl_t;

    ctl_t ctl_d;
    ctl_t ctl_q;

    logic              is_cond;
    logic [KIND_W-1:0] kind;
    logic [LEN_W-1:0]  len;
    logic [CYC_W-1:0]  cost;
    logic              arm;

    csc_cond_dec #(
        .OP_W       (OP_W),
        .COND_BASE  (COND_BASE),
        .COND_COUNT (COND_COUNT),
        .KIND_W     (KIND_W)
    ) u_cond (
        .opcode_i  (opcode_i),
        .is_cond_o (is_cond),
        .kind_o    (kind)
    );

    csc_len_dec #(
        .FA_W  (FA_W),
        .FB_W  (FB_W),
        .LEN_W (LEN_W)
    ) u_len (
        .fld_a_i (fld_a_i),
        .fld_b_i (fld_b_i),
        .len_o   (len)
    );

    csc_cost #(
        .CYC_W     (CYC_W),
        .COST_BASE (COST_BASE),
        .COST_FAIL (COST_FAIL),
        .COST_SKIP (COST_SKIP)
    ) u_cost (
        .skipping_i (ctl_q.skip),
        .is_cond_i  (is_cond),
        .pass_i     (test_pass_i),
        .cyc_o      (cost),
        .arm_o      (arm)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.valid = 1'b0;
        ctl_d.exec  = 1'b0;
        ctl_d.irq   = 1'b0;
        ctl_d.adv   = '0;
        ctl_d.cyc   = '0;
        if (step_i) begin
            ctl_d.valid = 1'b1;
            ctl_d.exec  = !ctl_q.skip;
            ctl_d.adv   = len;
            ctl_d.cyc   = cost;
            ctl_d.skip  = arm;
            ctl_d.irq   = irq_pend_i && !arm;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign cmp_kind_o  = kind;
    assign res_valid_o = ctl_q.valid;
    assign exec_o      = ctl_q.exec;
    assign pc_adv_o    = ctl_q.adv;
    assign cyc_add_o   = ctl_q.cyc;
    assign irq_take_o  = ctl_q.irq;
    assign skip_o      = ctl_q.skip;

endmodule

// File: rtl/cond_skip_chk.sv
`timescale 1ns/1ps
module cond_skip_chk #(
    parameter int unsigned OP_W   = 5,
    parameter int unsigned LEN_W  = 2,
    parameter int unsigned CYC_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              step_i,
    input logic [OP_W-1:0]   opcode_i,
    input logic              test_pass_i,
    input logic              irq_pend_i,
    input logic              res_valid_o,
    input logic              exec_o,
    input logic [LEN_W-1:0]  pc_adv_o,
    input logic [CYC_W-1:0]  cyc_add_o,
    input logic              irq_take_o,
    input logic              skip_o
);
    logic op_cond;
    assign op_cond = (opcode_i >= OP_W'(16)) && (opcode_i <= OP_W'(23));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> (!res_valid_o && skip_o == $past(skip_o)));

    assert_step_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> res_valid_o);

    assert_exec_live_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !skip_o) |=> exec_o);

    assert_skip_noexec_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && skip_o && !op_cond) |=> (!exec_o && !skip_o && cyc_add_o == '0));

    assert_chain_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && skip_o && op_cond) |=> (skip_o && cyc_add_o == CYC_W'(1)));

    assert_fail_arms_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !skip_o && op_cond && !test_pass_i) |=> (skip_o && cyc_add_o == CYC_W'(3)));

    assert_pass_cost_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !skip_o && op_cond && test_pass_i) |=> (!skip_o && cyc_add_o == CYC_W'(2)));

    assert_plain_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !op_cond) |=> (!skip_o && cyc_add_o == '0));

    assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take_o |-> (!skip_o && $past(irq_pend_i)));

    assert_len_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> (pc_adv_o != '0));
endmodule

bind cond_skip_ctrl cond_skip_chk #(
    .OP_W  (OP_W),
    .LEN_W (LEN_W),
    .CYC_W (CYC_W)
) u_cond_skip_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .step_i      (step_i),
    .opcode_i    (opcode_i),
    .test_pass_i (test_pass_i),
    .irq_pend_i  (irq_pend_i),
    .res_valid_o (res_valid_o),
    .exec_o      (exec_o),
    .pc_adv_o    (pc_adv_o),
    .cyc_add_o   (cyc_add_o),
    .irq_take_o  (irq_take_o),
    .skip_o      (skip_o)
);

// File: tb/test_cond_skip_ctrl.sv
`timescale 1ns/1ps
module test_cond_skip_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       step_i = 1'b0;
    logic [4:0] opcode_i = '0;
    logic [5:0] fld_a_i = '0;
    logic [4:0] fld_b_i = '0;
    logic       test_pass_i = 1'b0;
    logic       irq_pend_i = 1'b0;
    logic [2:0] cmp_kind_o;
    logic       res_valid_o;
    logic       exec_o;
    logic [1:0] pc_adv_o;
    logic [3:0] cyc_add_o;
    logic       irq_take_o;
    logic       skip_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    typedef struct {
        bit       exec;
        int       adv;
        int       cyc;
        bit       irq;
        bit       skip;
        string    tag;
    } exp_t;

    exp_t sb[$];
    bit   model_skip = 0;

    always #4 clk = ~clk;

    cond_skip_ctrl i_cond_skip_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_i      (step_i),
        .opcode_i    (opcode_i),
        .fld_a_i     (fld_a_i),
        .fld_b_i     (fld_b_i),
        .test_pass_i (test_pass_i),
        .irq_pend_i  (irq_pend_i),
        .cmp_kind_o  (cmp_kind_o),
        .res_valid_o (res_valid_o),
        .exec_o      (exec_o),
        .pc_adv_o    (pc_adv_o),
        .cyc_add_o   (cyc_add_o),
        .irq_take_o  (irq_take_o),
        .skip_o      (skip_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit uses_word(input int code);
        return (code >= 16 && code <= 23) || code == 26 || code == 30 || code == 31;
    endfunction

    // Driver: present one instruction and push its expected result
    task automatic drive(input int op, input int a, input int b, input bit pass,
                         input bit irq, input string tag);
        exp_t e;
        bit   cond;
        @(negedge clk);
        step_i      = 1'b1;
        opcode_i    = 5'(op);
        fld_a_i     = 6'(a);
        fld_b_i     = 5'(b);
        test_pass_i = pass;
        irq_pend_i  = irq;
        cond  = (op >= 16 && op <= 23);
        e.tag = tag;
        e.adv = 1 + int'(uses_word(a)) + int'(uses_word(b));
        e.exec = !model_skip;
        if (model_skip) begin
            e.cyc  = cond ? 1 : 0;
            e.skip = cond;
        end else if (cond) begin
            e.cyc  = pass ? 2 : 3;
            e.skip = !pass;
        end else begin
            e.cyc  = 0;
            e.skip = 0;
        end
        e.irq = irq && !e.skip;
        model_skip = e.skip;
        sb.push_back(e);
        #1;
        check({tag, " R10 kind"}, int'(cmp_kind_o), cond ? op - 16 : 0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            step_i = 1'b0;
            if (i > 0) begin
                check("R9 idle valid", int'(res_valid_o), 0);
                check("R9 idle skip", int'(skip_o), int'(model_skip));
            end
        end
    endtask

    // Monitor: pop and compare as results appear
    always @(negedge clk) begin
        if (rst_n && res_valid_o) begin
            if (sb.size() == 0) begin
                check("R9 unexpected result", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, " R11/R5 exec"}, int'(exec_o), int'(e.exec));
                check({e.tag, " R7 pc_adv"}, int'(pc_adv_o), e.adv);
                check({e.tag, " R3/R4/R6 cyc"}, int'(cyc_add_o), e.cyc);
                check({e.tag, " R8 irq"}, int'(irq_take_o), int'(e.irq));
                check({e.tag, " R4/R5/R6 skip"}, int'(skip_o), int'(e.skip));
            end
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 skip", int'(skip_o), 0);
        check("R1 valid", int'(res_valid_o), 0);
        check("R1 exec", int'(exec_o), 0);
        check("R1 irq", int'(irq_take_o), 0);
        rst_n = 1'b1;
        idle(2);

        drive(18, 0, 1, 1, 1, "R3 pass eq");
        drive(20, 31, 0, 0, 1, "R4 fail ugt");
        drive(1, 30, 16, 0, 1, "R5 skip plain len3");
        drive(1, 32, 3, 0, 1, "R11 plain exec");
        // chain: fail, two skipped conditionals, then a skipped plain op
        drive(23, 0, 0, 0, 0, "R4 fail slt");
        drive(21, 26, 0, 1, 1, "R6 skip cond sgt");
        idle(3);
        drive(16, 0, 31, 0, 1, "R6 skip cond bitset");
        drive(2, 0, 0, 1, 1, "R5 chain end");
        // non-conditional neighbours of the range
        drive(15, 0, 0, 0, 0, "R2 op 0x0f");
        drive(24, 0, 0, 0, 0, "R2 op 0x18");
        // length codes at the edges
        drive(1, 63, 26, 0, 0, "R7 literal+pick");
        drive(1, 23, 15, 0, 0, "R7 reg+next");
        // every condition kind, each passing
        for (int k = 16; k <= 23; k++) drive(k, 0, 0, 1, 0, "R10 kind sweep");
        // fail then skip with interrupt waiting
        drive(19, 0, 0, 0, 1, "R8 held");
        drive(17, 0, 0, 0, 1, "R8 held chain");
        drive(3, 0, 0, 0, 1, "R8 released");
        idle(4);
        check("R9 queue drained", sb.size(), 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule